// File: doc/BRIEF.md
# Disk Channel Strobe Timing Generator

This block times a single transfer cycle on a parallel disk channel that serves two drives. It runs three phases in a fixed order. First comes an address-setup phase with the strobe low. Next the strobe is held high for the active phase. Last comes a recovery phase with the strobe low again. A `busy` flag covers all three phases. The length of each phase comes from small timing registers that are loaded through a byte-wide write port. Each drive has a packed data-timing byte that gives its active and recovery counts. Each drive also has its own address-setup field.

Software loads the registers once for each drive's transfer mode. It then pulses `go` with `unit_sel` naming the drive. The block captures the counts for that drive when it accepts the pulse, so writes made during the cycle only take effect on the next one. The two per-drive setup fields are not used separately. The block always applies the slower of the two to whichever drive is selected.

Top module: `strobe_timer`

## Requirements
- R1: After reset `busy` and `dstrobe` are low and all four timing registers hold 0, so the first transfer uses 4 setup, 16 active and 16 recovery clocks.
- R2: A clock edge with `cfg_we` high stores `cfg_wdata` in the register chosen by `cfg_idx`. Index 0 is the data-timing byte of drive 0 and index 1 is that of drive 1. Index 2 is the setup byte of drive 0 and index 3 is that of drive 1. The setup code sits in bits 7:6 of a setup byte.
- R3: A `go` sampled high while idle raises `busy` at that edge. `busy` then stays high for S+A+R clocks. `dstrobe` is low for the first S clocks, high for the next A clocks and low for the last R clocks. After that `busy` returns low.
- R4: The active count A comes from bits 7:4 of the data-timing byte. A value v from 1 to 15 gives v clocks, and 0 gives 16 clocks.
- R5: The recovery count R comes from bits 3:0 of the data-timing byte. A code k from 1 to 15 gives k+1 clocks, and 0 gives 16 clocks.
- R6: Setup code 01 gives 2 clocks, 10 gives 3, 00 gives 4 and 11 gives 5.
- R7: The setup length S is the larger of the two drives' decoded setup lengths, whichever drive is selected.
- R8: A `go` pulse that arrives while `busy` is high is ignored. It neither restarts nor lengthens the running cycle.
- R9: Counts are captured when `go` is accepted. A register write made during a cycle leaves that cycle unchanged and applies to the next one.
- R10: `unit_sel` (0 or 1) selects which drive's data-timing byte supplies A and R.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing register write enable |
| cfg_idx | input | 2 | Timing register index |
| cfg_wdata | input | 8 | Timing register write data |
| go | input | 1 | Start-of-cycle pulse |
| unit_sel | input | 1 | Drive selected for the cycle |
| dstrobe | output | 1 | Read/write strobe, high during the active phase |
| busy | output | 1 | High from cycle acceptance until recovery ends |

## Verification
The bench aims at the count encodings that wrap. An active value of 0 and recovery codes 0, 1 and 15 are used. A design that read 0 as zero clocks, or that forgot the +1 on recovery, would return a strobe or a busy window that is short by one to sixteen clocks. Setup pairs are chosen so that the larger value sometimes belongs to the drive that is not selected. A design that took only the selected drive's field would start the strobe early. A second `go` during the active phase and a register rewrite during a cycle check that nothing retriggers and that the captured counts are not refreshed. A failing design would show a longer busy window or a changed strobe length.

// File: rtl/strobe_timer_pkg.sv
package strobe_timer_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_ACT   = 2'd2,
    PH_REC   = 2'd3
  } phase_t;

  // setup code -> (clocks - 1): 01->1, 10->2, 00->3, 11->4
  function automatic logic [3:0] setup_m1(input logic [1:0] code);
    case (code)
      2'b01:   setup_m1 = 4'd1;
      2'b10:   setup_m1 = 4'd2;
      2'b11:   setup_m1 = 4'd4;
      default: setup_m1 = 4'd3;
    endcase
  endfunction

endpackage

// File: rtl/strobe_timer_regs.sv
module strobe_timer_regs #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DEPTH*DATA_W-1:0] all_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign all_q[g*DATA_W +: DATA_W] = mem[g];
  end

endmodule

// File: rtl/strobe_timer_decode.sv
module strobe_timer_decode #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic [DATA_W-1:0] dt0,
  input  logic [DATA_W-1:0] dt1,
  input  logic [DATA_W-1:0] su0,
  input  logic [DATA_W-1:0] su1,
  input  logic              sel,
  output logic [CNT_W-1:0]  act_m1,
  output logic [CNT_W-1:0]  rec_m1,
  output logic [CNT_W-1:0]  set_m1
);
  import strobe_timer_pkg::*;

  logic [DATA_W-1:0] dt;
  logic [CNT_W-1:0]  act_code, rec_code;
  logic [3:0]        s0, s1;

  always_comb begin
    dt       = sel ? dt1 : dt0;
    act_code = dt[DATA_W-1 -: CNT_W];
    rec_code = dt[CNT_W-1:0];
    // active value v -> v clocks, 0 wraps to 2**CNT_W
    act_m1   = act_code - 1'b1;
    // recovery code k -> k+1 clocks, 0 wraps to 2**CNT_W
    rec_m1   = (rec_code == '0) ? {CNT_W{1'b1}} : rec_code;
    s0       = setup_m1(su0[DATA_W-1 -: 2]);
    s1       = setup_m1(su1[DATA_W-1 -: 2]);
    set_m1   = CNT_W'((s0 > s1) ? s0 : s1);
  end

endmodule

// File: rtl/strobe_timer_seq.sv
module strobe_timer_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [CNT_W-1:0] set_m1,
  input  logic [CNT_W-1:0] act_m1,
  input  logic [CNT_W-1:0] rec_m1,
  output logic             strobe_o,
  output logic             busy_o
);
  import strobe_timer_pkg::*;

  phase_t           phase;
  logic [CNT_W-1:0] cnt, act_l, rec_l;
  logic             last;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      act_l    <= '0;
      rec_l    <= '0;
      strobe_o <= 1'b0;
      busy_o   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (go) begin
          phase  <= PH_SETUP;
          cnt    <= set_m1;
          act_l  <= act_m1;
          rec_l  <= rec_m1;
          busy_o <= 1'b1;
        end
        PH_SETUP: if (last) begin
          phase    <= PH_ACT;
          cnt      <= act_l;
          strobe_o <= 1'b1;
        end else cnt <= cnt - 1'b1;
        PH_ACT: if (last) begin
          phase    <= PH_REC;
          cnt      <= rec_l;
          strobe_o <= 1'b0;
        end else cnt <= cnt - 1'b1;
        default: if (last) begin
          phase  <= PH_IDLE;
          busy_o <= 1'b0;
        end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  // R3: strobe only inside a busy window
  a_r3_strobe_in_busy: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> busy_o);
  // R3/R6: setup is at least two clocks, so strobe is low when busy rises
  a_r3_setup_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !strobe_o);
  // R5: recovery is at least two clocks
  a_r5_rec_min: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_o) |=> busy_o);
  // R8: a go while busy never ends the cycle early
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy_o && go && phase != PH_REC) |=> busy_o);

endmodule

// File: rtl/strobe_timer.sv
module strobe_timer #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4,
  parameter int NREGS  = 4,
  localparam int IDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              go,
  input  logic              unit_sel,
  output logic              dstrobe,
  output logic              busy
);

  logic [NREGS*DATA_W-1:0] regs_q;
  logic [CNT_W-1:0]        act_m1, rec_m1, set_m1;

  strobe_timer_regs #(.DATA_W(DATA_W), .DEPTH(NREGS)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .idx(cfg_idx),
    .wdata(cfg_wdata), .all_q(regs_q)
  );

  strobe_timer_decode #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
    .dt0(regs_q[0*DATA_W +: DATA_W]),
    .dt1(regs_q[1*DATA_W +: DATA_W]),
    .su0(regs_q[2*DATA_W +: DATA_W]),
    .su1(regs_q[3*DATA_W +: DATA_W]),
    .sel(unit_sel),
    .act_m1(act_m1), .rec_m1(rec_m1), .set_m1(set_m1)
  );

  strobe_timer_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .go(go),
    .set_m1(set_m1), .act_m1(act_m1), .rec_m1(rec_m1),
    .strobe_o(dstrobe), .busy_o(busy)
  );

  // R6/R7: accepted setup length lies between 2 and 5 clocks
  a_r6_setup_range: assert property (@(posedge clk) disable iff (rst)
    (go && !busy) |-> (set_m1 >= CNT_W'(1) && set_m1 <= CNT_W'(4)));

endmodule

// File: tb/strobe_timer_test.sv
`timescale 1ns/1ps
module strobe_timer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_idx = '0;
  logic [7:0] cfg_wdata = '0;
  logic       go = 1'b0;
  logic       unit_sel = 1'b0;
  logic       dstrobe, busy;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  strobe_timer uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .go(go), .unit_sel(unit_sel),
    .dstrobe(dstrobe), .busy(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] idx, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // runs one cycle; optional extra go at index go_at, optional write at wr_at
  task automatic xfer(input string req, input logic drv,
                      input int s, input int a, input int r,
                      input int go_at, input int wr_at,
                      input logic [1:0] widx, input logic [7:0] wdat);
    int first_st = -1;
    int st_len = 0;
    int busy_len = 0;
    @(negedge clk);
    unit_sel = drv; go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    for (int i = 0; i < 80; i++) begin
      if (busy) busy_len++;
      if (dstrobe) begin
        st_len++;
        if (first_st < 0) first_st = i;
      end
      go = (i == go_at);
      if (i == wr_at) begin
        cfg_we = 1'b1; cfg_idx = widx; cfg_wdata = wdat;
      end else cfg_we = 1'b0;
      @(negedge clk);
    end
    go = 1'b0; cfg_we = 1'b0;
    check({req, " setup"}, first_st, s);
    check({req, " active"}, st_len, a);
    check({req, " busy"}, busy_len, s + a + r);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 strobe", dstrobe, 0);
    xfer("R1 defaults", 1'b0, 4, 16, 16, -1, -1, 2'd0, 8'h00);
  endtask

  task automatic t_modes();
    // multiword mode 2 at 5 ns: 14 active, 10 recovery -> 0xE9 (R2, R10)
    wr(2'd0, 8'hE9);
    // multiword mode 1 at 5 ns: 16 active, 14 recovery -> 0x0D (R4 wrap)
    wr(2'd1, 8'h0D);
    wr(2'd2, 8'h40); wr(2'd3, 8'h40); // both setup 01 -> 2 (R6)
    xfer("R10 drv0", 1'b0, 2, 14, 10, -1, -1, 2'd0, 8'h00);
    xfer("R4 drv1", 1'b1, 2, 16, 14, -1, -1, 2'd0, 8'h00);
  endtask

  task automatic t_rec_edges();
    wr(2'd0, 8'h1F); // active 1, recovery code 15 -> 16 (R5)
    xfer("R5 code15", 1'b0, 2, 1, 16, -1, -1, 2'd0, 8'h00);
    wr(2'd0, 8'h21); // active 2, recovery code 1 -> 2 (R5)
    xfer("R5 code1", 1'b0, 2, 2, 2, -1, -1, 2'd0, 8'h00);
  endtask

  task automatic t_setup_max();
    wr(2'd2, 8'hC0); wr(2'd3, 8'h40); // 11->5 vs 01->2 (R7)
    xfer("R7 max drv1", 1'b1, 5, 16, 14, -1, -1, 2'd0, 8'h00);
    wr(2'd2, 8'h80); wr(2'd3, 8'h00); // 10->3 vs 00->4 (R6, R7)
    xfer("R7 max drv0", 1'b0, 4, 2, 2, -1, -1, 2'd0, 8'h00);
  endtask

  task automatic t_go_busy();
    // second go during the active phase (R8)
    xfer("R8 ignored", 1'b0, 4, 2, 2, 4, -1, 2'd0, 8'h00);
    check("R8 idle after", busy, 0);
  endtask

  task automatic t_snapshot();
    // rewrite drive0 data byte mid-cycle (R9)
    xfer("R9 current", 1'b0, 4, 2, 2, -1, 1, 2'd0, 8'h33);
    xfer("R9 next", 1'b0, 4, 3, 4, -1, -1, 2'd0, 8'h00);
  endtask

  initial begin
    #500000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_modes();
    t_rec_edges();
    t_setup_max();
    t_go_busy();
    t_snapshot();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule